// File: doc/BRIEF.md
# Four-Channel Edge Interrupt and Event Counter

This peripheral watches four asynchronous input lines. Each line is brought into the clock domain by a two-flop synchroniser, and each rising edge becomes one event. A channel works in one of two modes. In direct mode every event sets the channel's pending flag. In counter mode the channel counts events down from a loaded set value. When the count is used up, the channel sets its pending flag, reloads from the same set value and keeps counting. A pending flag that is not masked drives the channel's interrupt request output. The flag stays set until the channel's acknowledge input or a clear command removes it.

Software reaches the block through a plain register bus: one write strobe, an address, write data and combinational read data. The bus carries no stream traffic, so there is no valid/ready handshake. A write takes effect on the clock edge on which the strobe is high. A set-value register only stages a number; the count uses it only after a refresh command is issued. Clearing a mask through the ordinary mask command also puts the channel back into direct mode.

Address map: 0 to 3 hold the set values, 4 is the refresh command, 5 the mask word, 6 the pending-clear command, 7 the mode word (read only), and 8 to 11 the count readback for channels 0 to 3.

Top module: `irqc_top`

## Requirements
- R1: A rising edge on `in_pin[c]` is seen as one event after two synchroniser flops. If the pin is first sampled high at clock edge k, the channel's pending flag and request change at edge k+2, which is the third edge to see the pin high.
- R2: In direct mode each event sets pending bit c. `irq_req[c]` is high exactly while pending bit c is 1 and mask bit c is 0.
- R3: A write to address 4 refreshes every channel c whose data bit c is 0. The refresh copies set-value register c into the channel's active set value, loads the count, clears mask bit c and selects counter mode (mode bit c = 1). Channels whose bit is 1 are left unchanged. Readback (address 8+c) then shows the set value minus one, for example 0x0009 for 0x000A.
- R4: A write to a set-value register (addresses 0 to 3) does not change the running count or the reload value until the next refresh.
- R5: In counter mode each event lowers the readback by one. An event while the readback is 0 sets the pending flag and reloads the readback to the active set value minus one.
- R6: A refresh during counting puts the readback back to the set value minus one. An event in the same cycle as a refresh is dropped.
- R7: A set value of 0 stands for 65,536 events. The readback after a refresh is 0xFFFF, and the next event gives 0xFFFE without an interrupt.
- R8: A write to address 5 sets mask bit c to data bit c. Writing 0 to a bit unmasks the channel and returns it to direct mode. A masked channel still sets its pending flag but holds its request low. Address 5 reads back the mask bits.
- R9: Pending bit c (read at address 6) is cleared by `irq_ack[c]` or by writing 1 to bit c of address 6. An event in the same cycle wins over the clear.
- R10: After reset all mask bits are 1, all mode bits (address 7) are 0, all pending bits, requests and readbacks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_pin | input | 4 | Asynchronous event inputs, one per channel |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from `bus_addr`) |
| irq_req | output | 4 | Interrupt request per channel |
| irq_ack | input | 4 | Acknowledge per channel, clears the pending flag |

## Verification
The bench measures the exact synchroniser latency. A design with one flop too many or too few raises the request one cycle late or early. It stages a new set value while a channel is counting and checks that the count ignores it until the next refresh and then reloads from it. A design that reloads from the live register would show the wrong readback after the wrap. It refreshes a channel part way through a count and sets a zero set value, which catch a count that does not restart and a divide that wraps at the wrong place. It also clears a mask through the plain path and checks that the next edge interrupts at once, as direct mode does, and does not keep counting.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {MODE_DIRECT = 1'b0, MODE_COUNT = 1'b1} chan_mode_e;

  localparam int unsigned ADDR_REFRESH = 4;
  localparam int unsigned ADDR_MASK    = 5;
  localparam int unsigned ADDR_CLEAR   = 6;
  localparam int unsigned ADDR_MODE    = 7;
  localparam int unsigned ADDR_PV_BASE = 8;
endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R1: an edge is one event, never two in a row
  p_single_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irqc_channel.sv
module irqc_channel
  import irqc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          sv_we,
  input  logic [DW-1:0] sv_wdata,
  input  logic          refresh,
  input  logic          mask_we,
  input  logic          mask_val,
  input  logic          clr,
  input  logic          ack,
  output logic [DW-1:0] sv_q,
  output logic [DW-1:0] pv_q,
  output logic          cnt_mode,
  output logic          mask_q,
  output logic          pend_q,
  output logic          irq
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] live_q;
  chan_mode_e    mode_q;
  logic          wrap;
  logic          hit;

  assign cnt_mode = (mode_q == MODE_COUNT);
  assign wrap     = (pv_q == '0);
  assign hit      = evt & ~refresh & (~cnt_mode | wrap);
  assign irq      = pend_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sv_q   <= '0;
      live_q <= '0;
      pv_q   <= '0;
      mode_q <= MODE_DIRECT;
      mask_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (sv_we) sv_q <= sv_wdata;
      if (refresh) begin
        live_q <= sv_q;
        pv_q   <= sv_q - ONE;
        mode_q <= MODE_COUNT;
        mask_q <= 1'b0;
      end else begin
        if (mask_we) begin
          mask_q <= mask_val;
          if (!mask_val) mode_q <= MODE_DIRECT;
        end
        if (cnt_mode && evt) pv_q <= wrap ? live_q - ONE : pv_q - ONE;
      end
      pend_q <= (pend_q & ~(clr | ack)) | hit;
    end
  end

  p_refresh_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (pv_q == $past(sv_q) - ONE) && cnt_mode && !mask_q);

  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh && !(cnt_mode && evt)) |=> $stable(pv_q) && $stable(live_q));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && evt && !wrap && !refresh) |=> pv_q == $past(pv_q) - ONE);

  p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode && evt && wrap && !refresh) |=> pend_q && (pv_q == $past(live_q) - ONE));

  p_direct_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_mode && evt && !refresh) |=> pend_q);

  p_plain_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !mask_val && !refresh) |=> !cnt_mode && !mask_q);

  p_clear_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack || clr) && !hit) |=> !pend_q);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] in_pin,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq_req,
  input  logic [NCH-1:0] irq_ack
);
  logic [NCH-1:0] evt;
  logic [NCH-1:0] mode_vec, mask_vec, pend_vec;
  logic [DW-1:0]  sv_arr [NCH];
  logic [DW-1:0]  pv_arr [NCH];

  logic wr_refresh, wr_mask, wr_clear;
  assign wr_refresh = bus_we && (bus_addr == AW'(ADDR_REFRESH));
  assign wr_mask    = bus_we && (bus_addr == AW'(ADDR_MASK));
  assign wr_clear   = bus_we && (bus_addr == AW'(ADDR_CLEAR));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    irqc_edge_det #(.STAGES(SYNC)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (in_pin[c]),
      .rise (evt[c])
    );

    irqc_channel #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt[c]),
      .sv_we   (bus_we && (bus_addr == AW'(c))),
      .sv_wdata(bus_wdata),
      .refresh (wr_refresh && !bus_wdata[c]),
      .mask_we (wr_mask),
      .mask_val(bus_wdata[c]),
      .clr     (wr_clear && bus_wdata[c]),
      .ack     (irq_ack[c]),
      .sv_q    (sv_arr[c]),
      .pv_q    (pv_arr[c]),
      .cnt_mode(mode_vec[c]),
      .mask_q  (mask_vec[c]),
      .pend_q  (pend_vec[c]),
      .irq     (irq_req[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADDR_MASK)) bus_rdata[NCH-1:0] = mask_vec;
    if (bus_addr == AW'(ADDR_CLEAR)) bus_rdata[NCH-1:0] = pend_vec;
    if (bus_addr == AW'(ADDR_MODE)) bus_rdata[NCH-1:0] = mode_vec;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(i)) bus_rdata = sv_arr[i];
      if (bus_addr == AW'(ADDR_PV_BASE + i)) bus_rdata = pv_arr[i];
    end
  end

  // R10: first cycle out of reset shows every channel masked and quiet
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_vec == '1) && (pend_vec == '0) && (mode_vec == '0));
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_pin = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irq_req;
  logic [3:0]  irq_ack = '0;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .in_pin(in_pin), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_ack(irq_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, one step per clock edge
  bit [15:0] m_sv [4];
  bit [15:0] m_live [4];
  bit [15:0] m_pv [4];
  bit        m_cnt [4];
  bit        m_mask [4];
  bit        m_pend [4];
  bit        m_p1 [4];
  bit        m_p2 [4];
  bit        m_p3 [4];

  always @(posedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (!rst_n) begin
        m_sv[c] = 0; m_live[c] = 0; m_pv[c] = 0; m_cnt[c] = 0;
        m_mask[c] = 1; m_pend[c] = 0; m_p1[c] = 0; m_p2[c] = 0; m_p3[c] = 0;
      end else begin
        bit ev, rf, hit, old_cnt;
        ev = m_p2[c] && !m_p3[c];
        m_p3[c] = m_p2[c]; m_p2[c] = m_p1[c]; m_p1[c] = in_pin[c];
        rf = bus_we && bus_addr == 4 && !bus_wdata[c];
        old_cnt = m_cnt[c];
        hit = ev && !rf && (!old_cnt || m_pv[c] == 0);
        if (rf) begin
          m_live[c] = m_sv[c]; m_pv[c] = m_sv[c] - 16'd1; m_cnt[c] = 1; m_mask[c] = 0;
        end else begin
          if (bus_we && bus_addr == 5) begin
            m_mask[c] = bus_wdata[c];
            if (!bus_wdata[c]) m_cnt[c] = 0;
          end
          if (old_cnt && ev) m_pv[c] = (m_pv[c] == 0) ? m_live[c] - 16'd1 : m_pv[c] - 16'd1;
        end
        if (irq_ack[c] || (bus_we && bus_addr == 6 && bus_wdata[c])) m_pend[c] = 0;
        if (hit) m_pend[c] = 1;
        if (bus_we && bus_addr == 4'(c)) m_sv[c] = bus_wdata;
      end
    end
  end

  // every-clock comparison of the request outputs
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      for (int c = 0; c < 4; c++) begin
        checks++;
        if (irq_req[c] !== (m_pend[c] && !m_mask[c])) begin
          errors++;
          $display("FAIL R2/R8 irq_req[%0d] act %b exp %b", c, irq_req[c], m_pend[c] && !m_mask[c]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input int c);
    @(negedge clk); in_pin[c] = 1;
    @(negedge clk);
    @(negedge clk); in_pin[c] = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic model_word(input int a, output logic [15:0] d);
    d = 0;
    for (int c = 0; c < 4; c++) begin
      if (a == 5) d[c] = m_mask[c];
      if (a == 6) d[c] = m_pend[c];
      if (a == 7) d[c] = m_cnt[c];
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d, e;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    rd(5, d); chk("R10 mask", d, 16'h000F);
    rd(6, d); chk("R10 pending", d, 16'h0000);
    rd(7, d); chk("R10 mode", d, 16'h0000);
    for (int c = 0; c < 4; c++) begin
      rd(4'(8 + c), d); chk("R10 readback", d, 16'h0000);
    end
    chk("R10 irq", {12'd0, irq_req}, 16'h0000);

    // R1 latency and R2 direct event
    wr(5, 16'h0000);
    @(negedge clk); in_pin[0] = 1;
    @(negedge clk);
    @(negedge clk); chk("R1 after two edges", {15'd0, irq_req[0]}, 16'd0);
    @(negedge clk); chk("R1 after three edges", {15'd0, irq_req[0]}, 16'd1);
    in_pin[0] = 0;
    rd(6, d); chk("R2 pending", d, 16'h0001);

    // R9 acknowledge and clear command
    @(negedge clk); irq_ack[0] = 1;
    @(negedge clk); irq_ack[0] = 0;
    rd(6, d); chk("R9 ack clears", d, 16'h0000);

    // R8 masked channel sets pending, no request
    wr(5, 16'h0002);
    pulse(1);
    rd(6, d); chk("R8 masked pending", d, 16'h0002);
    chk("R8 masked quiet", {15'd0, irq_req[1]}, 16'd0);
    wr(6, 16'h0002);
    rd(6, d); chk("R9 clear command", d, 16'h0000);

    // R3 refresh into counter mode
    wr(0, 16'h000A);
    wr(4, 16'h000E);
    rd(8, d); chk("R3 readback sv-1", d, 16'h0009);
    rd(7, d); chk("R3 mode bit", d, 16'h0001);
    rd(5, d); chk("R3 mask cleared", d, 16'h0002);

    // R5 counting down
    for (int i = 0; i < 3; i++) pulse(0);
    rd(8, d); chk("R5 count step", d, 16'h0006);

    // R4 staged set value ignored until refresh
    wr(0, 16'h0003);
    rd(8, d); chk("R4 count unchanged", d, 16'h0006);
    for (int i = 0; i < 6; i++) pulse(0);
    rd(8, d); chk("R5 reached zero", d, 16'h0000);
    chk("R5 no irq yet", {15'd0, irq_req[0]}, 16'd0);
    pulse(0);
    chk("R5 irq at wrap", {15'd0, irq_req[0]}, 16'd1);
    rd(8, d); chk("R4 reload from latched value", d, 16'h0009);
    @(negedge clk); irq_ack[0] = 1;
    @(negedge clk); irq_ack[0] = 0;
    wr(4, 16'h000E);
    rd(8, d); chk("R4 new value after refresh", d, 16'h0002);

    // R6 refresh mid-count restarts
    pulse(0);
    rd(8, d); chk("R6 stepped", d, 16'h0001);
    wr(4, 16'h000E);
    rd(8, d); chk("R6 restarted", d, 16'h0002);
    chk("R6 no irq", {15'd0, irq_req[0]}, 16'd0);

    // R7 zero set value
    wr(2, 16'h0000);
    wr(4, 16'h000B);
    rd(10, d); chk("R7 readback", d, 16'hFFFF);
    pulse(2);
    rd(10, d); chk("R7 one event", d, 16'hFFFE);
    chk("R7 no irq", {15'd0, irq_req[2]}, 16'd0);

    // R8 plain unmask drops to direct mode
    wr(5, 16'h0000);
    rd(7, d); chk("R8 direct mode", d, 16'h0000);
    pulse(0);
    chk("R8 direct edge irq", {15'd0, irq_req[0]}, 16'd1);
    wr(6, 16'h000F);

    // R9 event and clear in the same cycle: event wins
    @(negedge clk); in_pin[3] = 1;
    @(negedge clk);
    @(negedge clk); bus_we = 1; bus_addr = 6; bus_wdata = 16'h0008;
    @(negedge clk); bus_we = 0; in_pin[3] = 0;
    rd(6, d); chk("R9 event wins", d, 16'h0008);

    // model consistency sweep
    for (int a = 5; a < 8; a++) begin
      rd(4'(a), d); model_word(a, e); chk("R10 model word", d, e);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule